// File: doc/BRIEF.md
# Miss Status Target Tracker

This block holds the bookkeeping for one outstanding cache miss. An allocation captures the block address, the access size, the cycle at which the miss may issue and its global order number. It also records the first requester as the head of an active target list. Later requests to the same block are attached as extra targets. While the miss is being serviced, some of them must wait for a second round. Those requests go to a deferred list instead of the active one.

The routing decision depends on four things: whether service has started, whether a snoop has left an invalidation pending, whether the deferred list already holds anything, and whether the new request wants exclusive ownership that the outstanding request did not ask for. Snoops from the memory side attach only during service, and only when exclusivity is involved. When service completes, the active list is retired and the deferred list becomes the new active list. The order number and issue time are then refreshed from the promoted head. Both lists are FIFOs of parameterised depth, built as two storage banks whose roles swap on promotion, so no entries are copied.

Top module: `miss_target_tracker`

## Requirements
- R1: After reset, every count is 0, and the busy, in-service, exclusive, deferred-exclusive, pending-invalidate and stall outputs are all 0.
- R2: An allocate strobe stores the request's address, size, ready time and order. It sets the active count and the total to 1 and the deferred count to 0. It clears in-service, deferred-exclusive and pending-invalidate, and sets busy. The exclusive flag takes the request's exclusive bit. The head target shows the receive cycle (the number of clock edges since reset was released, counted from 0), the request's ready time and order, a CPU-side flag of 1 and its exclusive bit.
- R3: When busy and not in service, an added target always joins the active list, and an exclusive target sets the exclusive flag.
- R4: When in service, an added target goes to the deferred list if the deferred list is non-empty, or an invalidation is pending, or the target is exclusive while the exclusive flag is 0. A deferred exclusive target sets the deferred-exclusive flag.
- R5: When in service and none of the R4 conditions hold, an added target joins the active list.
- R6: A snoop target is accepted into the active list only when busy, in service, and either the exclusive flag or the snoop's exclusive bit is 1. An accepted exclusive snoop sets pending-invalidate. Any other snoop changes nothing.
- R7: A service-complete strobe while in service with a non-empty deferred list moves the deferred targets to the active list. The total becomes the old deferred count and the deferred count becomes 0. The exclusive flag takes the old deferred-exclusive value, and deferred-exclusive, pending-invalidate and in-service clear. The order becomes the promoted head's order, and the ready time becomes the larger of the current receive cycle and the promoted head's ready time.
- R8: A service-complete strobe while in service with an empty deferred list clears busy, in-service, the exclusive flags and all counts. A service-complete strobe while not in service has no effect.
- R9: An add or accepted snoop aimed at a full list is dropped. The counts are unchanged and the stall output is 1 for exactly the following cycle.
- R10: The total count rises by one on every accepted add or snoop, whichever list it enters, and always equals the active count plus the deferred count.
- R11: Only one strobe acts per cycle, by priority: allocate, service-complete, service-start, add, snoop. Add and service-start are ignored when not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate the tracker for a new miss |
| add_i | input | 1 | Attach a CPU-side target |
| snoop_i | input | 1 | Attach a memory-side snoop target |
| svc_start_i | input | 1 | Outstanding request has been issued |
| svc_done_i | input | 1 | Outstanding request has completed |
| req_addr_i | input | ADDR_W | Block address (allocate) |
| req_size_i | input | SIZE_W | Access size (allocate) |
| req_ready_i | input | TIME_W | Cycle at which the request may issue |
| req_order_i | input | ORD_W | Global order number of the request |
| req_excl_i | input | 1 | Request needs exclusive ownership |
| busy_o | output | 1 | Tracker holds a miss |
| in_service_o | output | 1 | Outstanding request is in service |
| needs_excl_o | output | 1 | Outstanding request wants exclusivity |
| def_needs_excl_o | output | 1 | A deferred target wants exclusivity |
| pend_inval_o | output | 1 | An invalidation is pending |
| stall_o | output | 1 | Previous add or snoop was dropped on a full list |
| act_cnt_o | output | CNT_W | Active target count |
| def_cnt_o | output | CNT_W | Deferred target count |
| total_o | output | TOT_W | Total target count |
| addr_o | output | ADDR_W | Stored block address |
| size_o | output | SIZE_W | Stored access size |
| ready_o | output | TIME_W | Issue time of the miss |
| order_o | output | ORD_W | Order number of the miss |
| head_recv_o | output | TIME_W | Receive cycle of the active head target |
| head_ready_o | output | TIME_W | Ready time of the active head target |
| head_order_o | output | ORD_W | Order number of the active head target |
| head_cpu_o | output | 1 | Active head target came from the CPU side |
| head_excl_o | output | 1 | Active head target is exclusive |

## Verification
The bench builds the tracker with a list depth of 3 and the default 16-bit time and 8-bit order widths. With that depth, an allocation, a pending-invalidate snoop and one probe target all fit in the active list, and both lists can be filled to their stall point in a handful of cycles. A sweep walks every reachable combination of deferred-list occupancy, pending invalidation, outstanding exclusivity and probe exclusivity. Each case is then promoted, with deferred ready times above and below the current cycle so that both arms of the ready-time maximum are covered.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

  // Action chosen for one cycle; priority is fixed in the top module.
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_ALLOC = 3'd1,
    ACT_DONE  = 3'd2,
    ACT_START = 3'd3,
    ACT_ADD   = 3'd4,
    ACT_SNOOP = 3'd5
  } mtt_act_e;

endpackage

// File: rtl/mtt_fifo.sv
// Append-only target list; head is always entry 0. Storage has no reset so
// it can map onto distributed or block RAM.
module mtt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] widx;
  logic             wr_en;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign widx  = flush ? '0 : IDX_W'(cnt);
  assign wr_en = push && (flush || !full);
  assign head  = mem[0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (flush)          cnt <= push ? CNT_W'(1) : '0;
    else if (push && !full)  cnt <= cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> !full);  // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));  // R10

endmodule

// File: rtl/mtt_route.sv
// Decides where an add or snoop lands and whether it is dropped.
module mtt_route (
  input  logic add_req,
  input  logic snoop_req,
  input  logic busy,
  input  logic in_svc,
  input  logic def_any,
  input  logic pend_inval,
  input  logic needs_excl,
  input  logic req_excl,
  input  logic act_full,
  input  logic def_full,
  output logic push_act,
  push_def,
  output logic refused,
  output logic snoop_taken
);
  logic add_go, snoop_go, to_def;

  always_comb begin
    add_go   = add_req && busy;
    snoop_go = snoop_req && busy && in_svc && (needs_excl || req_excl);
    to_def   = in_svc && (def_any || pend_inval || (!needs_excl && req_excl));

    push_def    = add_go && to_def && !def_full;
    push_act    = (add_go && !to_def && !act_full) || (snoop_go && !act_full);
    snoop_taken = snoop_go && !act_full;
    refused     = (add_go && to_def && def_full)
               || (add_go && !to_def && act_full)
               || (snoop_go && act_full);
  end

endmodule

// File: rtl/miss_target_tracker.sv
module miss_target_tracker
  import mtt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4,
  parameter int TIME_W = 16,
  parameter int ORD_W  = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TOT_W = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic              add_i,
  input  logic              snoop_i,
  input  logic              svc_start_i,
  input  logic              svc_done_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [TIME_W-1:0] req_ready_i,
  input  logic [ORD_W-1:0]  req_order_i,
  input  logic              req_excl_i,
  output logic              busy_o,
  output logic              in_service_o,
  output logic              needs_excl_o,
  output logic              def_needs_excl_o,
  output logic              pend_inval_o,
  output logic              stall_o,
  output logic [CNT_W-1:0]  act_cnt_o,
  output logic [CNT_W-1:0]  def_cnt_o,
  output logic [TOT_W-1:0]  total_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [TIME_W-1:0] ready_o,
  output logic [ORD_W-1:0]  order_o,
  output logic [TIME_W-1:0] head_recv_o,
  output logic [TIME_W-1:0] head_ready_o,
  output logic [ORD_W-1:0]  head_order_o,
  output logic              head_cpu_o,
  output logic              head_excl_o
);
  localparam int TGT_W = 2 * TIME_W + ORD_W + 2;

  typedef struct packed {
    logic [TIME_W-1:0] recv;
    logic [TIME_W-1:0] ready;
    logic [ORD_W-1:0]  order;
    logic              cpu;
    logic              excl;
  } tgt_t;

  // Free-running receive-cycle counter
  logic [TIME_W-1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else     cyc_q <= cyc_q + 1'b1;
  end

  // One action per cycle, fixed priority
  mtt_act_e act;
  always_comb begin
    if (alloc_i)          act = ACT_ALLOC;
    else if (svc_done_i)  act = ACT_DONE;
    else if (svc_start_i) act = ACT_START;
    else if (add_i)       act = ACT_ADD;
    else if (snoop_i)     act = ACT_SNOOP;
    else                  act = ACT_NONE;
  end

  // Two banks; sel_q names the one holding the active list
  logic             sel_q;
  logic [TGT_W-1:0] f_head  [2];
  logic [CNT_W-1:0] f_cnt   [2];
  logic             f_full  [2];
  logic             f_push  [2];
  logic             f_flush [2];

  logic push_act, push_def, refused, snoop_taken;
  logic do_done;
  tgt_t new_tgt, act_head, def_head;

  assign act_head = tgt_t'(f_head[sel_q]);
  assign def_head = tgt_t'(f_head[~sel_q]);
  assign do_done  = (act == ACT_DONE) && in_service_o;

  always_comb begin
    new_tgt.recv  = cyc_q;
    new_tgt.ready = req_ready_i;
    new_tgt.order = req_order_i;
    new_tgt.cpu   = (act != ACT_SNOOP);
    new_tgt.excl  = req_excl_i;
  end

  mtt_route u_route (
    .add_req    (act == ACT_ADD),
    .snoop_req  (act == ACT_SNOOP),
    .busy       (busy_o),
    .in_svc     (in_service_o),
    .def_any    (def_cnt_o != '0),
    .pend_inval (pend_inval_o),
    .needs_excl (needs_excl_o),
    .req_excl   (req_excl_i),
    .act_full   (f_full[sel_q]),
    .def_full   (f_full[~sel_q]),
    .push_act   (push_act),
    .push_def   (push_def),
    .refused    (refused),
    .snoop_taken(snoop_taken)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      if (sel_q == 1'(b)) f_push[b] = push_act || (act == ACT_ALLOC);
      else                f_push[b] = push_def;
      f_flush[b] = (act == ACT_ALLOC) || (do_done && sel_q == 1'(b));
    end

    mtt_fifo #(.W(TGT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_list (
      .clk  (clk),
      .rst  (rst),
      .flush(f_flush[b]),
      .push (f_push[b]),
      .wdata(new_tgt),
      .head (f_head[b]),
      .cnt  (f_cnt[b]),
      .full (f_full[b])
    );
  end

  assign act_cnt_o    = f_cnt[sel_q];
  assign def_cnt_o    = f_cnt[~sel_q];
  assign head_recv_o  = act_head.recv;
  assign head_ready_o = act_head.ready;
  assign head_order_o = act_head.order;
  assign head_cpu_o   = act_head.cpu;
  assign head_excl_o  = act_head.excl;

  // Miss record and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q            <= 1'b0;
      busy_o           <= 1'b0;
      in_service_o     <= 1'b0;
      needs_excl_o     <= 1'b0;
      def_needs_excl_o <= 1'b0;
      pend_inval_o     <= 1'b0;
      stall_o          <= 1'b0;
      total_o          <= '0;
      addr_o           <= '0;
      size_o           <= '0;
      ready_o          <= '0;
      order_o          <= '0;
    end else begin
      stall_o <= refused;
      unique case (act)
        ACT_ALLOC: begin
          busy_o           <= 1'b1;
          in_service_o     <= 1'b0;
          needs_excl_o     <= req_excl_i;
          def_needs_excl_o <= 1'b0;
          pend_inval_o     <= 1'b0;
          total_o          <= TOT_W'(1);
          addr_o           <= req_addr_i;
          size_o           <= req_size_i;
          ready_o          <= req_ready_i;
          order_o          <= req_order_i;
        end
        ACT_DONE: begin
          if (in_service_o) begin
            sel_q            <= ~sel_q;
            in_service_o     <= 1'b0;
            needs_excl_o     <= def_needs_excl_o;
            def_needs_excl_o <= 1'b0;
            pend_inval_o     <= 1'b0;
            total_o          <= TOT_W'(def_cnt_o);
            busy_o           <= (def_cnt_o != '0);
            if (def_cnt_o != '0) begin
              order_o <= def_head.order;
              ready_o <= (cyc_q > def_head.ready) ? cyc_q : def_head.ready;
            end
          end
        end
        ACT_START: begin
          if (busy_o) in_service_o <= 1'b1;
        end
        ACT_ADD, ACT_SNOOP: begin
          if (push_act || push_def) total_o <= total_o + 1'b1;
          if (push_def) def_needs_excl_o <= def_needs_excl_o | req_excl_i;
          if (push_act && !snoop_taken) needs_excl_o <= needs_excl_o | req_excl_i;
          if (snoop_taken) pend_inval_o <= pend_inval_o | req_excl_i;
        end
        default: ;
      endcase
    end
  end

  AST_TOTAL_SUM: assert property (@(posedge clk) disable iff (rst)
    total_o == TOT_W'(act_cnt_o) + TOT_W'(def_cnt_o));  // R10
  AST_DEF_NEEDS_SVC: assert property (@(posedge clk) disable iff (rst)
    (def_cnt_o != '0) |-> in_service_o);  // R4
  AST_ALLOC_INIT: assert property (@(posedge clk) disable iff (rst)
    alloc_i |=> (total_o == TOT_W'(1)) && (act_cnt_o == CNT_W'(1)) && (def_cnt_o == '0));  // R2
  AST_SNOOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (snoop_i && !alloc_i && !svc_done_i && !svc_start_i && !add_i && !in_service_o)
      |=> $stable(act_cnt_o) && $stable(total_o));  // R6
  AST_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (svc_done_i && !alloc_i && in_service_o && def_cnt_o != '0)
      |=> (act_cnt_o == $past(def_cnt_o)) && (def_cnt_o == '0) && !in_service_o);  // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $stable(total_o));  // R9

endmodule

// File: tb/test_miss_target_tracker.sv
module test_miss_target_tracker;
  localparam int AW = 16, SW = 4, TW = 16, OW = 8, D = 3;
  localparam int CW = $clog2(D + 1);
  localparam int TOTW = $clog2(2 * D + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_i = 0, add_i = 0, snoop_i = 0, svc_start_i = 0, svc_done_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [SW-1:0] req_size_i = '0;
  logic [TW-1:0] req_ready_i = '0;
  logic [OW-1:0] req_order_i = '0;
  logic req_excl_i = 0;
  logic busy_o, in_service_o, needs_excl_o, def_needs_excl_o, pend_inval_o, stall_o;
  logic [CW-1:0] act_cnt_o, def_cnt_o;
  logic [TOTW-1:0] total_o;
  logic [AW-1:0] addr_o;
  logic [SW-1:0] size_o;
  logic [TW-1:0] ready_o, head_recv_o, head_ready_o;
  logic [OW-1:0] order_o, head_order_o;
  logic head_cpu_o, head_excl_o;

  always #5 clk = ~clk;

  miss_target_tracker #(.ADDR_W(AW), .SIZE_W(SW), .TIME_W(TW), .ORD_W(OW), .DEPTH(D))
  i_miss_target_tracker (.*);

  int n_vec = 0, n_bad = 0, tb_cyc = 0;

  // Reference state derived from the requirements
  int m_busy, m_svc, m_nx, m_dnx, m_pend, m_stall, m_act, m_def, m_tot;
  int m_addr, m_size, m_ready, m_order;
  int h_recv, h_ready, h_order, h_cpu, h_excl;
  int d_recv, d_ready, d_order, d_cpu, d_excl;

  task automatic chk(string tag, string nm, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "busy", int'(busy_o), m_busy);
    chk(tag, "in_service", int'(in_service_o), m_svc);
    chk(tag, "needs_excl", int'(needs_excl_o), m_nx);
    chk(tag, "def_needs_excl", int'(def_needs_excl_o), m_dnx);
    chk(tag, "pend_inval", int'(pend_inval_o), m_pend);
    chk(tag, "stall", int'(stall_o), m_stall);
    chk(tag, "act_cnt", int'(act_cnt_o), m_act);
    chk(tag, "def_cnt", int'(def_cnt_o), m_def);
    chk(tag, "total", int'(total_o), m_tot);
    chk(tag, "addr", int'(addr_o), m_addr);
    chk(tag, "size", int'(size_o), m_size);
    chk(tag, "ready", int'(ready_o), m_ready);
    chk(tag, "order", int'(order_o), m_order);
    if (m_act > 0) begin
      chk(tag, "head_recv", int'(head_recv_o), h_recv);
      chk(tag, "head_ready", int'(head_ready_o), h_ready);
      chk(tag, "head_order", int'(head_order_o), h_order);
      chk(tag, "head_cpu", int'(head_cpu_o), h_cpu);
      chk(tag, "head_excl", int'(head_excl_o), h_excl);
    end
  endtask

  task automatic model(int c);
    int ex = int'(req_excl_i);
    int to_def;
    m_stall = 0;
    if (alloc_i) begin
      m_busy = 1; m_svc = 0; m_nx = ex; m_dnx = 0; m_pend = 0;
      m_act = 1; m_def = 0; m_tot = 1;
      m_addr = int'(req_addr_i); m_size = int'(req_size_i);
      m_ready = int'(req_ready_i); m_order = int'(req_order_i);
      h_recv = c; h_ready = m_ready; h_order = m_order; h_cpu = 1; h_excl = ex;
    end else if (svc_done_i) begin
      if (m_svc == 1) begin
        if (m_def > 0) begin
          m_act = m_def; m_tot = m_def;
          m_order = d_order; m_ready = (c > d_ready) ? c : d_ready;
          h_recv = d_recv; h_ready = d_ready; h_order = d_order; h_cpu = d_cpu; h_excl = d_excl;
        end else begin
          m_act = 0; m_tot = 0; m_busy = 0;
        end
        m_def = 0; m_svc = 0; m_nx = m_dnx; m_dnx = 0; m_pend = 0;
      end
    end else if (svc_start_i) begin
      if (m_busy == 1) m_svc = 1;
    end else if (add_i) begin
      if (m_busy == 1) begin
        to_def = (m_svc == 1) && (m_def > 0 || m_pend == 1 || (m_nx == 0 && ex == 1));
        if (to_def) begin
          if (m_def == D) m_stall = 1;
          else begin
            if (m_def == 0) begin
              d_recv = c; d_ready = int'(req_ready_i); d_order = int'(req_order_i);
              d_cpu = 1; d_excl = ex;
            end
            m_def++; m_tot++; m_dnx = m_dnx | ex;
          end
        end else if (m_act == D) m_stall = 1;
        else begin m_act++; m_tot++; m_nx = m_nx | ex; end
      end
    end else if (snoop_i) begin
      if (m_busy == 1 && m_svc == 1 && (m_nx == 1 || ex == 1)) begin
        if (m_act == D) m_stall = 1;
        else begin m_act++; m_tot++; m_pend = m_pend | ex; end
      end
    end
  endtask

  // Apply the currently set strobes for one clock edge
  task automatic step();
    model(tb_cyc);
    @(posedge clk);
    #1;
    tb_cyc++;
    alloc_i = 0; add_i = 0; snoop_i = 0; svc_start_i = 0; svc_done_i = 0;
  endtask

  task automatic set_req(int a, int s, int r, int o, int e);
    req_addr_i = AW'(a); req_size_i = SW'(s); req_ready_i = TW'(r);
    req_order_i = OW'(o); req_excl_i = e[0];
  endtask

  task automatic do_alloc(int a, int s, int r, int o, int e);
    set_req(a, s, r, o, e); alloc_i = 1; step();
  endtask
  task automatic do_add(int r, int o, int e);
    set_req(0, 0, r, o, e); add_i = 1; step();
  endtask
  task automatic do_snoop(int e);
    set_req(0, 0, 7, 200, e); snoop_i = 1; step();
  endtask
  task automatic do_start(); svc_start_i = 1; step(); endtask
  task automatic do_done(); svc_done_i = 1; step(); endtask

  initial begin : watchdog
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    m_busy = 0; m_svc = 0; m_nx = 0; m_dnx = 0; m_pend = 0; m_stall = 0;
    m_act = 0; m_def = 0; m_tot = 0; m_addr = 0; m_size = 0; m_ready = 0; m_order = 0;
    h_recv = 0; h_ready = 0; h_order = 0; h_cpu = 0; h_excl = 0;
    d_recv = 0; d_ready = 0; d_order = 0; d_cpu = 0; d_excl = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    tb_cyc = 0;
    check_all("R1");

    // R11: add, snoop, start and done before any allocation change nothing
    do_add(5, 5, 1);      check_all("R11");
    do_snoop(1);          check_all("R11");
    do_start();           check_all("R11");
    do_done();            check_all("R8");

    // R2/R3: allocate then adds outside service, fill to stall (R9)
    do_alloc(16'h1234, 9, 40, 11, 0);  check_all("R2");
    do_add(41, 12, 0);                 check_all("R3");
    do_add(42, 13, 1);                 check_all("R3");
    do_add(43, 14, 0);                 check_all("R9");
    do_snoop(1);                       check_all("R6");
    do_start();                        check_all("R11");
    do_add(44, 15, 0);                 check_all("R9");
    do_start();                        check_all("R9");

    // R9 deferred side, then R7 promotion of a full deferred list
    do_alloc(16'h0abc, 3, 60, 20, 0);
    do_start();                        check_all("R4");
    do_add(16'h0400, 21, 1);           check_all("R4");
    do_add(2, 22, 0);                  check_all("R4");
    do_add(3, 23, 1);                  check_all("R10");
    do_add(4, 24, 0);                  check_all("R9");
    do_done();                         check_all("R7");
    do_done();                         check_all("R8");
    do_start();                        check_all("R11");
    do_done();                         check_all("R8");

    // R6: snoop gating
    do_alloc(16'h0055, 1, 8, 30, 0);
    do_snoop(1);                       check_all("R6");
    do_start();
    do_snoop(0);                       check_all("R6");
    do_snoop(1);                       check_all("R6");
    do_add(9, 31, 0);                  check_all("R4");

    // R11: priority between simultaneous strobes
    set_req(16'h0777, 2, 50, 40, 1);
    alloc_i = 1; add_i = 1; snoop_i = 1; step();
    check_all("R11");
    do_start();
    svc_done_i = 1; svc_start_i = 1; step();
    check_all("R11");

    // Sweep: deferred occupancy, pending invalidate, outstanding excl, probe excl
    for (int c = 0; c < 16; c++) begin
      int dn = c & 1, pn = (c >> 1) & 1, nx = (c >> 2) & 1, ex = (c >> 3) & 1;
      if (dn == 1 && nx == 1 && pn == 0) continue;
      do_alloc(c * 17 + 3, c, 100 + c, c, nx);   check_all("R2");
      do_start();                                check_all("R5");
      if (pn == 1) begin do_snoop(1);            check_all("R6"); end
      if (dn == 1) begin
        do_add(((c & 2) != 0) ? 2 : 16'h0400, 50 + c, (nx == 0) ? 1 : 0);
        check_all("R4");
      end
      do_add(300 + c, 80 + c, ex);               check_all("R5");
      check_all("R4");
      do_done();                                 check_all("R7");
      do_start();                                check_all("R10");
      do_done();                                 check_all("R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule